// File: doc/BRIEF.md
# SPI Slave Stall Watchdog

This block watches an SPI slave transfer for a stalled serial clock. While the synchronized slave select is active and a programmable 16-bit limit is non-zero, the first serial clock edge arms a counter of system clocks. Every later serial clock edge sets the count back to zero, so the count is the time since the most recent edge. If the count reaches the limit before the transfer is reported complete, a sticky time-out flag is raised. The flag stays high until a clear pulse removes it.

The counter stops at the limit and does not wrap. A completed transfer, a zero limit or an inactive select each set the count to zero and disarm the counter. After that, counting starts again only on a new serial clock edge. The serial data path and the register interface sit outside this block. They supply the pulses and the limit and read back the flag and the count.

Top module: `spi_stall_watchdog`

## Requirements
- R1: After a synchronous active-low reset, `timeout_flag` is 0 and `stall_count` is 0.
- R2: With select active and a non-zero limit, no counting happens until a serial clock edge pulse is seen. Asserting select alone leaves `stall_count` at 0.
- R3: The serial clock edge pulse is sampled at an edge. At that edge `stall_count` becomes 0 and the counter is armed. It then rises by one on each following clock. When the count equals the limit L (L clocks after the arming edge), `timeout_flag` rises on the next clock edge.
- R4: Once `stall_count` has reached the limit, it holds that value until something clears it.
- R5: Each serial clock edge pulse while armed sets `stall_count` back to 0, and counting resumes from there.
- R6: A transfer-done pulse sets `stall_count` to 0 and disarms the counter on the next edge. If the pulse comes on the same cycle as a time-out condition, the flag is not set.
- R7: Select going inactive sets `stall_count` to 0 and disarms the counter. Counting does not resume when select returns until a new serial clock edge arrives.
- R8: A limit of 0 disables the watchdog. It sets `stall_count` to 0, disarms the counter and blocks arming while it stays 0.
- R9: `timeout_flag` is sticky: only `flag_clr` lowers it. A clear in the same cycle as a set condition wins, so the flag is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_active | input | 1 | Synchronized slave select, 1 = transfer selected |
| sclk_edge | input | 1 | One-cycle pulse per serial clock edge |
| xfer_done | input | 1 | One-cycle pulse when a transfer completes |
| limit | input | 16 | Time-out threshold in system clocks, 0 = disabled |
| flag_clr | input | 1 | One-cycle pulse that clears the time-out flag |
| timeout_flag | output | 1 | Sticky time-out indication |
| stall_count | output | 16 | System clocks since the last serial clock edge |

## Verification
The embedded assertions check on every cycle that:
- the count only ever steps up by one or returns to zero;
- an inactive select or a zero limit leaves a zero count;
- a held count stays stable at the limit;
- a clear always lowers the flag;
- the flag stays high without a clear;
- a done pulse never raises the flag.

Only the directed scenarios can show the exact clock on which the flag rises relative to the arming edge. The same is true for the absence of counting before the first serial edge, and for re-arming requiring a fresh edge after select returns or the limit is restored.

// File: rtl/spi_wd_pkg.sv
// Shared definitions for the SPI stall watchdog.
// Assumes all users agree on the counter width given here.
package spi_wd_pkg;
    localparam int WD_CNT_W = 16;

    // Operation the control logic requests from the stall counter.
    typedef enum logic [1:0] {
        CNT_CLEAR   = 2'd0,
        CNT_RESTART = 2'd1,
        CNT_STEP    = 2'd2,
        CNT_HOLD    = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/wd_arm_ctrl.sv
// Arm control: decides when the stall counter is armed and which operation
// it performs each cycle.
// Assumes sel_active is already synchronized and pulses are one clock wide.
module wd_arm_ctrl
    import spi_wd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_active,
    input  logic    sclk_edge,
    input  logic    xfer_done,
    input  logic    limit_zero,
    input  logic    at_limit,
    output logic    armed,
    output cnt_op_e cnt_op
);
    logic kill;

    // Any condition that ends or disables a watch window.
    always_comb kill = !sel_active || limit_zero || xfer_done;

    // Arm on a serial edge, disarm on any kill condition.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed <= 1'b0;
        else if (kill)      armed <= 1'b0;
        else if (sclk_edge) armed <= 1'b1;
    end

    // Select the counter operation; clearing outranks restarting.
    always_comb begin
        if (kill)                   cnt_op = CNT_CLEAR;
        else if (sclk_edge)         cnt_op = CNT_RESTART;
        else if (armed && !at_limit) cnt_op = CNT_STEP;
        else                        cnt_op = CNT_HOLD;
    end

    AST_ARM_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(sclk_edge)); // R2
endmodule

// File: rtl/wd_stall_counter.sv
// Stall counter: counts system clocks as told by the arm control.
// Assumes CNT_STEP is only requested below the limit, so it never wraps.
module wd_stall_counter
    import spi_wd_pkg::*;
#(
    parameter int CNT_W = WD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          cnt_op,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Apply the requested counter operation.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else begin
            unique case (cnt_op)
                CNT_CLEAR, CNT_RESTART: count <= '0;
                CNT_STEP:               count <= count + ONE;
                default:                count <= count;
            endcase
        end
    end

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == '0 || count == $past(count) + ONE)); // R3
endmodule

// File: rtl/wd_flag.sv
// Sticky time-out flag: set by a hit, lowered only by the clear pulse.
// Assumes the hit already excludes the done cycle.
module wd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    // Clear has priority over a simultaneous set.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else if (hit) flag <= 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R9
endmodule

// File: rtl/spi_stall_watchdog.sv
// SPI slave stall watchdog top level.
// Measures system clocks since the last serial clock edge while a slave
// transfer is selected, and raises a sticky flag when the count reaches the
// limit. Assumes synchronized select and one-cycle pulses from the data path.
module spi_stall_watchdog
    import spi_wd_pkg::*;
#(
    parameter int CNT_W = WD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_active,
    input  logic             sclk_edge,
    input  logic             xfer_done,
    input  logic [CNT_W-1:0] limit,
    input  logic             flag_clr,
    output logic             timeout_flag,
    output logic [CNT_W-1:0] stall_count
);
    logic    limit_zero;
    logic    at_limit;
    logic    armed;
    logic    hit;
    cnt_op_e cnt_op;

    // Limit decode and comparison against the running count.
    always_comb begin
        limit_zero = (limit == '0);
        at_limit   = (stall_count >= limit);
    end

    // Time-out condition; a done pulse in the same cycle suppresses it.
    always_comb hit = armed && at_limit && !limit_zero && sel_active && !xfer_done;

    wd_arm_ctrl u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_active (sel_active),
        .sclk_edge  (sclk_edge),
        .xfer_done  (xfer_done),
        .limit_zero (limit_zero),
        .at_limit   (at_limit),
        .armed      (armed),
        .cnt_op     (cnt_op)
    );

    wd_stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_op (cnt_op),
        .count  (stall_count)
    );

    wd_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (flag_clr),
        .flag  (timeout_flag)
    );

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_active |=> stall_count == '0); // R7
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        limit_zero |=> stall_count == '0); // R8
    AST_HOLD_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !sclk_edge) |=> $stable(stall_count)); // R4
    AST_DONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !timeout_flag) |=> !timeout_flag); // R6
endmodule

// File: tb/spi_stall_watchdog_tb_top.sv
// Directed bench for the SPI stall watchdog; one task per scenario.
module spi_stall_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_active = 1'b0;
    logic        sclk_edge = 1'b0;
    logic        xfer_done = 1'b0;
    logic [15:0] limit = 16'd0;
    logic        flag_clr = 1'b0;
    logic        timeout_flag;
    logic [15:0] stall_count;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    spi_stall_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .sel_active(sel_active), .sclk_edge(sclk_edge),
        .xfer_done(xfer_done), .limit(limit), .flag_clr(flag_clr),
        .timeout_flag(timeout_flag), .stall_count(stall_count)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge_pulse();
        sclk_edge = 1'b1; tick(); sclk_edge = 1'b0;
    endtask

    task automatic quiet();
        sel_active = 1'b0; flag_clr = 1'b1; tick(); flag_clr = 1'b0; tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(2); rst_n = 1'b1;
        chk("R1 flag", timeout_flag, 0);
        chk("R1 count", stall_count, 0);
    endtask

    task automatic t_no_edge();
        sel_active = 1'b1; limit = 16'd5; tick(10);
        chk("R2 count", stall_count, 0);
        chk("R2 flag", timeout_flag, 0);
        quiet();
    endtask

    task automatic t_timeout();
        sel_active = 1'b1; limit = 16'd5;
        edge_pulse();
        chk("R3 arm count", stall_count, 0);
        tick(5);
        chk("R3 count at limit", stall_count, 5);
        chk("R3 flag not yet", timeout_flag, 0);
        tick();
        chk("R3 flag rise", timeout_flag, 1);
        tick(3);
        chk("R4 hold", stall_count, 5);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R9 clear wins", timeout_flag, 0);
        tick();
        chk("R9 reset again", timeout_flag, 1);
        sel_active = 1'b0; tick(3);
        chk("R9 sticky", timeout_flag, 1);
        chk("R7 count cleared", stall_count, 0);
        quiet();
    endtask

    task automatic t_restart();
        sel_active = 1'b1; limit = 16'd20;
        edge_pulse(); tick(3);
        chk("R5 before", stall_count, 3);
        edge_pulse();
        chk("R5 restart", stall_count, 0);
        tick(2);
        chk("R5 resume", stall_count, 2);
        quiet();
    endtask

    task automatic t_done();
        sel_active = 1'b1; limit = 16'd5;
        edge_pulse(); tick(5);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        chk("R6 no flag", timeout_flag, 0);
        chk("R6 count", stall_count, 0);
        tick(8);
        chk("R6 disarmed", stall_count, 0);
        chk("R6 flag stays low", timeout_flag, 0);
        quiet();
    endtask

    task automatic t_select();
        sel_active = 1'b1; limit = 16'd9;
        edge_pulse(); tick(3);
        sel_active = 1'b0; tick();
        chk("R7 cleared", stall_count, 0);
        sel_active = 1'b1; tick(4);
        chk("R7 needs edge", stall_count, 0);
        edge_pulse(); tick(2);
        chk("R7 rearmed", stall_count, 2);
        quiet();
    endtask

    task automatic t_zero_limit();
        sel_active = 1'b1; limit = 16'd9;
        edge_pulse(); tick(2);
        limit = 16'd0; tick();
        chk("R8 cleared", stall_count, 0);
        edge_pulse(); tick(3);
        chk("R8 no arm", stall_count, 0);
        limit = 16'd9; tick(3);
        chk("R8 stays idle", stall_count, 0);
        chk("R8 no flag", timeout_flag, 0);
        quiet();
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        t_reset();
        t_no_edge();
        t_timeout();
        t_restart();
        t_done();
        t_select();
        t_zero_limit();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule